// File: doc/BRIEF.md
# Interval Timer Pair with Limit Reload

This block holds two interval timers: one that belongs to a single processor and one shared master timer. Both count microsecond ticks, taken from a 1 MHz enable pulse supplied from outside. Each timer counts up from zero. When the next count would reach the programmed limit, the timer returns to zero, sets a sticky limit-reached flag and holds its interrupt request high. The processor-local timer drives the level-14 request. The master timer drives the level-10 request. Software clears a request by reading the timer's limit register.

Registers are reached through a request/response pair with valid/ready handshakes. A request carries a 3-bit word address, a write bit and 32 bits of write data. Reads return exactly one response. Writes return none. The block takes a new request only when no response is waiting, or when the waiting response is taken in the same cycle. While the response side is stalled, the response data stays unchanged. Word addresses 0 to 3 reach the processor-local timer and 4 to 7 reach the master timer. Within each group the order is: limit, count, limit-without-clear, auxiliary.

Top module: `ivl_timer_pair`

## Requirements
- R1: After reset every limit, count and flag is zero, both interrupt requests are low, no response is pending, req_ready is high, and the master auxiliary word (word address 7) reads 0.
- R2: Each cycle with tick_1us high adds one to both counts. A read of a count word (1 or 5) returns the flag in bit 31, the count in bits 30:10 and zero in bits 9:0.
- R3: When a tick would make the count equal to or greater than the effective limit, the count goes to 0 and the flag is set on that same edge. The period is therefore limit ticks. A limit of 0 counts as 2^21 ticks.
- R4: The processor-local flag drives irq_l14 and the master flag drives irq_l10. Each timer changes only its own request. A request stays high until that timer's limit word is read or written.
- R5: A read of a limit word (0 or 4) returns the flag in bit 31 and the limit in bits 30:10. The read then clears the flag. If a wrap happens on the same edge, the flag stays set.
- R6: Reading a count word has no side effect. Writes to a count word are ignored.
- R7: A write to a limit word loads bits 30:10 as the new limit, sets the count to 0 and clears the flag. Bits 31 and 9:0 of the write data are ignored, and the write takes priority over a tick on the same edge.
- R8: A write to a limit-without-clear word (2 or 6) loads only the limit and leaves the count and the flag as they were. Reading that word returns the same value as the limit word, with no side effect.
- R9: Word 7 is a 32-bit read/write auxiliary register. Word 3 reads as zero and ignores writes.
- R10: A request is accepted on an edge where req_valid and req_ready are both high. req_ready is low while a response is pending and rsp_ready is low. Response data does not change until the response is taken.
- R11: A read accepted at one edge shows rsp_valid high from the next cycle. Its data is the register value just before that edge. Write effects are visible from the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_1us | input | 1 | One-cycle 1 MHz count enable |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Block can take the request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_waddr | input | 3 | Word address; bit 2 selects the master timer |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_data | output | 32 | Read response data |
| irq_l14 | output | 1 | Processor-local timer request (level 14) |
| irq_l10 | output | 1 | Master timer request (level 10) |

## Verification
Count, flag and request changes caused by a tick show up one cycle after the tick edge. The effects of an accepted access show up one cycle after its acceptance edge, and read data is valid from that same cycle until it is taken. The bench drives ticks and requests on falling edges and never overlaps them. It samples every output on the falling edge after the edge that should cause the change. Expected counts and flags come from a bench function of the ticks given since the last limit write and the limit value. The bench holds responses for random stall lengths to check that data stays stable under back-pressure.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = 21;
  localparam int CNT_LSB = 10;
  localparam int WADDR_W = 3;
  localparam int N_TMR   = 2;
  localparam int TMR_CPU = 0;
  localparam int TMR_MST = 1;

  typedef enum logic [1:0] {
    REG_LIMIT = 2'd0,
    REG_COUNT = 2'd1,
    REG_LIMNC = 2'd2,
    REG_AUX   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ivl_timer_core.sv
module ivl_timer_core #(
  parameter int CNT_W = ivl_timer_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             ld_clr_i,
  input  logic             ld_keep_i,
  input  logic             rd_clr_i,
  input  logic [CNT_W-1:0] lim_wr_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] limit_o,
  output logic             flag_o
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, lim_q;
  logic             flg_q;
  logic [EXT_W-1:0] cnt_inc, lim_eff;
  logic             wrap;

  // zero limit means the full 2^CNT_W range
  always_comb begin
    cnt_inc = {1'b0, cnt_q} + EXT_W'(1);
    lim_eff = (lim_q == '0) ? (EXT_W'(1) << CNT_W) : {1'b0, lim_q};
    wrap    = tick_i && (cnt_inc >= lim_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
      flg_q <= 1'b0;
    end else if (ld_clr_i) begin
      cnt_q <= '0;
      lim_q <= lim_wr_i;
      flg_q <= 1'b0;
    end else begin
      if (ld_keep_i) lim_q <= lim_wr_i;
      if (tick_i)    cnt_q <= wrap ? '0 : cnt_inc[CNT_W-1:0];
      if (wrap)          flg_q <= 1'b1;
      else if (rd_clr_i) flg_q <= 1'b0;
    end
  end

  assign count_o = cnt_q;
  assign limit_o = lim_q;
  assign flag_o  = flg_q;
endmodule

// File: rtl/ivl_reg_port.sv
module ivl_reg_port
  import ivl_timer_pkg::*;
#(
  parameter int DW  = ivl_timer_pkg::DATA_W,
  parameter int CW  = ivl_timer_pkg::CNT_W,
  parameter int LSB = ivl_timer_pkg::CNT_LSB,
  parameter int NT  = ivl_timer_pkg::N_TMR
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [WADDR_W-1:0]    req_waddr,
  input  logic [DW-1:0]         req_wdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [DW-1:0]         rsp_data,
  output logic [NT-1:0]         ld_clr_o,
  output logic [NT-1:0]         ld_keep_o,
  output logic [NT-1:0]         rd_clr_o,
  output logic [CW-1:0]         lim_wr_o,
  input  logic [NT-1:0][CW-1:0] cnt_i,
  input  logic [NT-1:0][CW-1:0] lim_i,
  input  logic [NT-1:0]         flg_i
);
  localparam logic [LSB-1:0] LOW_ZERO = '0;

  logic          acc, blk;
  reg_sel_e      sel;
  logic [DW-1:0] rd_word, cfg_q, rsp_q;
  logic          rsp_v_q;

  assign req_ready = !rsp_v_q || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign blk       = req_waddr[WADDR_W-1];
  assign sel       = reg_sel_e'(req_waddr[1:0]);
  assign lim_wr_o  = req_wdata[LSB+CW-1:LSB];

  for (genvar t = 0; t < NT; t++) begin : g_strobe
    logic hit;
    assign hit          = acc && (blk == 1'(t));
    assign ld_clr_o[t]  = hit &&  req_write && (sel == REG_LIMIT);
    assign ld_keep_o[t] = hit &&  req_write && (sel == REG_LIMNC);
    assign rd_clr_o[t]  = hit && !req_write && (sel == REG_LIMIT);
  end

  always_comb begin
    rd_word = '0;
    unique case (sel)
      REG_LIMIT, REG_LIMNC: rd_word = {flg_i[blk], lim_i[blk], LOW_ZERO};
      REG_COUNT:            rd_word = {flg_i[blk], cnt_i[blk], LOW_ZERO};
      REG_AUX:              rd_word = blk ? cfg_q : '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v_q <= 1'b0;
      rsp_q   <= '0;
      cfg_q   <= '0;
    end else begin
      if (acc && !req_write) begin
        rsp_v_q <= 1'b1;
        rsp_q   <= rd_word;
      end else if (rsp_ready) begin
        rsp_v_q <= 1'b0;
      end
      if (acc && req_write && blk && (sel == REG_AUX)) cfg_q <= req_wdata;
    end
  end

  assign rsp_valid = rsp_v_q;
  assign rsp_data  = rsp_q;
endmodule

// File: rtl/ivl_timer_pair.sv
module ivl_timer_pair
  import ivl_timer_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_1us,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [WADDR_W-1:0] req_waddr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               irq_l14,
  output logic               irq_l10
);
  logic [N_TMR-1:0]            ld_clr, ld_keep, rd_clr, flg;
  logic [N_TMR-1:0][CNT_W-1:0] cnt, lim;
  logic [CNT_W-1:0]            lim_wr;

  ivl_reg_port #(.DW(DATA_W), .CW(CNT_W), .LSB(CNT_LSB), .NT(N_TMR)) u_port (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_waddr(req_waddr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .ld_clr_o(ld_clr), .ld_keep_o(ld_keep), .rd_clr_o(rd_clr), .lim_wr_o(lim_wr),
    .cnt_i(cnt), .lim_i(lim), .flg_i(flg)
  );

  for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
    ivl_timer_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_1us),
      .ld_clr_i(ld_clr[t]), .ld_keep_i(ld_keep[t]), .rd_clr_i(rd_clr[t]),
      .lim_wr_i(lim_wr), .count_o(cnt[t]), .limit_o(lim[t]), .flag_o(flg[t])
    );
  end

  assign irq_l14 = flg[TMR_CPU];
  assign irq_l10 = flg[TMR_MST];
endmodule

// File: rtl/ivl_timer_pair_chk.sv
module ivl_timer_pair_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_1us,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [2:0]  req_waddr,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_data,
  input logic        irq_l14,
  input logic        irq_l10
);
  logic acc;
  assign acc = req_valid && req_ready;

  p_rise_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_l14) |-> $past(tick_1us));

  p_irq_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_l14 && !(acc && req_waddr == 3'd0) |=> irq_l14);

  p_rd_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_write && req_waddr == 3'd4 && !tick_1us |=> !irq_l10);

  p_wr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_write && req_waddr == 3'd0 |=> !irq_l14);

  p_keep_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_l10 && acc && req_write && req_waddr == 3'd6 |=> irq_l10);

  p_stall_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  p_rsp_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  p_rd_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_write |=> rsp_valid);
endmodule

bind ivl_timer_pair ivl_timer_pair_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .req_waddr(req_waddr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_data(rsp_data), .irq_l14(irq_l14), .irq_l10(irq_l10)
);

// File: tb/ivl_timer_pair_tb_top.sv
module ivl_timer_pair_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1us = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [2:0]  req_waddr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_ready = 1'b0;
  logic        req_ready, rsp_valid, irq_l14, irq_l10;
  logic [31:0] rsp_data;
  int          n_chk = 0;
  int          n_fail = 0;
  logic [31:0] rd;

  always #4 clk = ~clk;

  ivl_timer_pair dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_waddr(req_waddr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .irq_l14(irq_l14), .irq_l10(irq_l10)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_word(input int t, input int lim);
    logic [20:0] c;
    c = 21'(t % lim);
    return {(t >= lim), c, 10'b0};
  endfunction

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_1us = 1'b1;
      @(negedge clk) tick_1us = 1'b0;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_waddr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk) req_valid = 1'b0;
  endtask

  task automatic rdreg(input logic [2:0] a, output logic [31:0] d);
    int stall;
    logic [31:0] first;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_waddr = a;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk) req_valid = 1'b0;
    chk("R11 rsp_valid after accept", {31'b0, rsp_valid}, 32'd1);
    first = rsp_data;
    stall = int'($urandom % 4);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk("R10 data held in stall", rsp_data, first);
      chk("R10 ready low in stall", {31'b0, req_ready}, 32'd0);
    end
    rsp_ready = 1'b1;
    d = rsp_data;
    @(posedge clk);
    @(negedge clk) rsp_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq_l14 reset", {31'b0, irq_l14}, 32'd0);
    chk("R1 irq_l10 reset", {31'b0, irq_l10}, 32'd0);
    chk("R1 rsp_valid reset", {31'b0, rsp_valid}, 32'd0);
    chk("R1 req_ready reset", {31'b0, req_ready}, 32'd1);
    rdreg(3'd1, rd); chk("R1 count reset", rd, 32'h0);
    rdreg(3'd0, rd); chk("R1 limit reset", rd, 32'h0);
    rdreg(3'd7, rd); chk("R1 aux reset", rd, 32'h0);

    wr(3'd7, 32'hA5A5_0001);
    rdreg(3'd7, rd); chk("R9 aux readback", rd, 32'hA5A5_0001);
    wr(3'd3, 32'hFFFF_FFFF);
    rdreg(3'd3, rd); chk("R9 word3 zero", rd, 32'h0);

    // local timer, limit 10 with junk in ignored bits
    wr(3'd0, 32'h8000_2BFF);
    rdreg(3'd0, rd); chk("R7 ignored bits", rd, 32'h0000_2800);
    ticks(9);
    chk("R3 no flag before limit", {31'b0, irq_l14}, 32'd0);
    rdreg(3'd1, rd); chk("R2 count 9", rd, 32'h0000_2400);
    ticks(1);
    chk("R4 irq_l14 set", {31'b0, irq_l14}, 32'd1);
    chk("R4 irq_l10 untouched", {31'b0, irq_l10}, 32'd0);
    rdreg(3'd1, rd); chk("R3 wrap to zero with flag", rd, 32'h8000_0000);
    chk("R6 count read keeps irq", {31'b0, irq_l14}, 32'd1);
    rdreg(3'd0, rd); chk("R5 limit read flag", rd, 32'h8000_2800);
    chk("R5 irq cleared by read", {31'b0, irq_l14}, 32'd0);

    ticks(3);
    wr(3'd1, 32'h7FFF_FC00);
    rdreg(3'd1, rd); chk("R6 count write ignored", rd, 32'h0000_0C00);

    ticks(7);
    chk("R4 second period", {31'b0, irq_l14}, 32'd1);
    ticks(2);
    wr(3'd2, 32'h0000_5000);
    rdreg(3'd1, rd); chk("R8 count and flag kept", rd, 32'h8000_0800);
    chk("R8 irq kept", {31'b0, irq_l14}, 32'd1);
    ticks(18);
    rdreg(3'd1, rd); chk("R8 new limit period", rd, 32'h8000_0000);
    rdreg(3'd2, rd); chk("R8 nc word read", rd, 32'h8000_5000);
    chk("R8 nc read no clear", {31'b0, irq_l14}, 32'd1);
    rdreg(3'd0, rd); chk("R5 clear after nc", {31'b0, irq_l14}, 32'd0);

    ticks(3);
    wr(3'd2, 32'h0000_0800);
    ticks(1);
    rdreg(3'd1, rd); chk("R3 shrink below count wraps", rd, 32'h8000_0000);
    wr(3'd0, 32'h0000_5000);
    rdreg(3'd1, rd); chk("R7 write resets count", rd, 32'h0);
    chk("R7 write clears irq", {31'b0, irq_l14}, 32'd0);

    wr(3'd0, 32'h0);
    ticks(3000);
    rdreg(3'd1, rd); chk("R3 zero limit long period", rd, 32'h002E_E000);

    for (int it = 0; it < 20; it++) begin
      int lim, t;
      lim = 1 + int'($urandom % 40);
      t   = int'($urandom % 100);
      wr(3'd4, 32'(lim) << 10);
      ticks(t);
      chk("R4 master irq", {31'b0, irq_l10}, {31'b0, (t >= lim)});
      rdreg(3'd5, rd); chk("R2 master count", rd, model_word(t, lim));
      rdreg(3'd4, rd); chk("R5 master limit", rd, {(t >= lim), 21'(lim), 10'b0});
      chk("R5 master irq cleared", {31'b0, irq_l10}, 32'd0);
      chk("R4 local irq untouched", {31'b0, irq_l14}, 32'd0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule